// File: doc/BRIEF.md
# Convolution, Rectify and Pool Feature Stage

This block turns a small two-row feature map into a six-value feature vector for a classifier. The block holds a frame of two rows of nine signed samples and three seven-tap kernels (21 coefficients). Both are written into internal registers through a simple write port while the block is idle. A start pulse launches one pass. A single seven-lane multiply-accumulate datapath evaluates one valid (unpadded) window per clock. The datapath steps across the columns of a row, then moves to the next row, then to the next kernel.

Each window sum is scaled, saturated to the sample width and rectified. A running maximum over the three window positions of a row then performs 1×3 max pooling. Each pooled value leaves on a one-cycle valid strobe. After the sixth value, a one-cycle completion pulse follows. The vector order is kernel-major, with the row as the minor index.

Top module: `conv_pool_stage`

## Requirements
- R1: After reset, `feat_valid`, `done` and `busy` are low.
- R2: A sample write with `smp_we` stores `smp_data` at index row*9+col. A coefficient write with `coef_we` stores `coef_data` at index kernel*7+tap. Tap 0 multiplies the leftmost sample of a window.
- R3: The window result at kernel k, row r, column c is the sum over t=0..6 of sample[r][c+t]*coef[k][t]. All operands are signed 16-bit. The sum is arithmetically shifted right by FRAC (8) bits.
- R4: A shifted window result above 32767 is clipped to 32767.
- R5: A negative window result becomes 0 before pooling, so no emitted value is negative.
- R6: Each emitted value is the maximum of the three rectified window results of one row of one kernel.
- R7: One pass emits exactly six values, in the order k0r0, k0r1, k1r0, k1r1, k2r0, k2r1.
- R8: With start sampled at clock edge 0, value j (j=0..5) is valid during the cycle after edge 3j+3. Each valid strobe lasts one cycle.
- R9: `done` is high for exactly one cycle, in the cycle after the sixth valid strobe.
- R10: While `busy` is high, `start`, `smp_we` and `coef_we` are ignored. No extra pass starts, and the stored frame and kernels are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_we | input | 1 | Sample write enable |
| smp_addr | input | 5 | Sample index, row*9+col |
| smp_data | input | 16 | Signed sample |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | 5 | Coefficient index, kernel*7+tap |
| coef_data | input | 16 | Signed coefficient |
| start | input | 1 | Pulse that launches a pass while idle |
| busy | output | 1 | A pass is in progress |
| feat_valid | output | 1 | `feat_data` holds a pooled value |
| feat_data | output | 16 | Pooled, rectified feature value |
| done | output | 1 | One-cycle pulse after the last value |

## Verification
Taking the edge that samples `start` as edge 0, pooled value j is due in the cycle after edge 3j+3, and the completion pulse is due after edge 19.

When the stimulus raises `start`, the driver records the cycle count. It queues each expected value together with the cycle in which it must appear. The monitor samples on the falling edge and compares the value and its arrival cycle against the head of the queue. Any strobe that arrives with nothing queued is a failure. Once a pass has drained, a stray start or write issued mid-pass must leave no trace.

// File: rtl/conv_pool_stage.sv
module conv_pool_stage #(
  parameter int DW    = 16,
  parameter int AW    = 36,
  parameter int FRAC  = 8,
  parameter int ROWS  = 2,
  parameter int COLS  = 9,
  parameter int TAPS  = 7,
  parameter int NFILT = 3,
  localparam int SAW  = $clog2(ROWS*COLS),
  localparam int CAW  = $clog2(NFILT*TAPS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           smp_we,
  input  logic [SAW-1:0] smp_addr,
  input  logic [DW-1:0]  smp_data,
  input  logic           coef_we,
  input  logic [CAW-1:0] coef_addr,
  input  logic [DW-1:0]  coef_data,
  input  logic           start,
  output logic           busy,
  output logic           feat_valid,
  output logic [DW-1:0]  feat_data,
  output logic           done
);
  localparam int OUTW = COLS - TAPS + 1;
  localparam int FW = (NFILT > 1) ? $clog2(NFILT) : 1;
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CW = (OUTW > 1) ? $clog2(OUTW) : 1;
  localparam logic signed [AW-1:0] MAXV = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};

  logic signed [DW-1:0] smp  [ROWS*COLS];
  logic signed [DW-1:0] coef [NFILT*TAPS];
  logic signed [AW-1:0] prod [TAPS];
  logic signed [AW-1:0] acc, shr;
  logic [FW-1:0] f_q;
  logic [RW-1:0] r_q;
  logic [CW-1:0] c_q;
  logic [DW-1:0] relu, runmax, pool_nxt;
  logic          fin_q;

  always_ff @(posedge clk) begin
    if (smp_we && !busy && int'(smp_addr) < ROWS*COLS) smp[smp_addr] <= smp_data;
    if (coef_we && !busy && int'(coef_addr) < NFILT*TAPS) coef[coef_addr] <= coef_data;
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_lane
    logic [SAW-1:0] si;
    logic [CAW-1:0] ci;
    assign si = SAW'(int'(r_q)*COLS + int'(c_q) + t);
    assign ci = CAW'(int'(f_q)*TAPS + t);
    assign prod[t] = AW'(smp[si]) * AW'(coef[ci]);
  end

  always_comb begin
    acc = '0;
    for (int t = 0; t < TAPS; t++) acc = acc + prod[t];
  end

  assign shr      = acc >>> FRAC;
  assign relu     = shr[AW-1] ? '0 : (shr > MAXV ? DW'(MAXV) : DW'(shr));
  assign pool_nxt = (c_q == '0 || relu > runmax) ? relu : runmax;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      feat_valid <= 1'b0;
      feat_data  <= '0;
      done       <= 1'b0;
      fin_q      <= 1'b0;
      runmax     <= '0;
      f_q        <= '0;
      r_q        <= '0;
      c_q        <= '0;
    end else begin
      feat_valid <= 1'b0;
      done       <= fin_q;
      fin_q      <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          f_q  <= '0;
          r_q  <= '0;
          c_q  <= '0;
        end
      end else begin
        runmax <= pool_nxt;
        if (c_q == CW'(OUTW-1)) begin
          feat_valid <= 1'b1;
          feat_data  <= pool_nxt;
          c_q        <= '0;
          if (r_q == RW'(ROWS-1)) begin
            r_q <= '0;
            if (f_q == FW'(NFILT-1)) begin
              f_q   <= '0;
              busy  <= 1'b0;
              fin_q <= 1'b1;
            end else begin
              f_q <= f_q + 1'b1;
            end
          end else begin
            r_q <= r_q + 1'b1;
          end
        end else begin
          c_q <= c_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/conv_pool_stage_chk.sv
module conv_pool_stage_chk #(
  parameter int DW   = 16,
  parameter int NOUT = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          feat_valid,
  input logic [DW-1:0] feat_data,
  input logic          done
);
  logic [7:0] vcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vcnt <= '0;
    else if (start && !busy) vcnt <= '0;
    else if (feat_valid) vcnt <= vcnt + 1'b1;
  end

  AST_VALID_IN_PASS: assert property (@(posedge clk) disable iff (!rst_n) feat_valid |-> $past(busy)); // R8
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) feat_valid |=> !feat_valid); // R8
  AST_NON_NEGATIVE: assert property (@(posedge clk) disable iff (!rst_n) feat_valid |-> $signed(feat_data) >= 0); // R5
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(feat_valid)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_SIX_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n) done |-> vcnt == 8'(NOUT)); // R7
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start)); // R10
endmodule

bind conv_pool_stage conv_pool_stage_chk #(.DW(DW), .NOUT(NFILT*ROWS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .feat_valid(feat_valid), .feat_data(feat_data), .done(done)
);

// File: tb/sim_conv_pool_stage.sv
module sim_conv_pool_stage;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_we = 1'b0, coef_we = 1'b0, start = 1'b0;
  logic [4:0] smp_addr = '0, coef_addr = '0;
  logic [15:0] smp_data = '0, coef_data = '0;
  logic busy, feat_valid, done;
  logic [15:0] feat_data;

  conv_pool_stage u0 (
    .clk(clk), .rst_n(rst_n), .smp_we(smp_we), .smp_addr(smp_addr), .smp_data(smp_data),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data), .start(start),
    .busy(busy), .feat_valid(feat_valid), .feat_data(feat_data), .done(done)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, exp_done = -1;
  int exp_val[$], exp_cyc[$];
  int bs[18], bc[21];
  string tag = "";
  bit ended = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_test();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic int model(int f, int r);
    longint s, best;
    best = 0;
    for (int c = 0; c < 3; c++) begin
      s = 0;
      for (int t = 0; t < 7; t++) s += longint'(bs[r*9+c+t]) * longint'(bc[f*7+t]);
      s = s >>> 8;
      if (s > 32767) s = 32767;
      if (s < 0) s = 0;
      if (s > best) best = s;
    end
    return int'(best);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (feat_valid) begin
        if (exp_val.size() == 0) begin
          check(0, {"R7 R10 unexpected output ", tag}, int'(feat_data), -1);
        end else begin
          int ev, ec;
          ev = exp_val.pop_front();
          ec = exp_cyc.pop_front();
          check(int'(feat_data) == ev, {"R3 R6 R7 value ", tag}, int'(feat_data), ev);
          check(cyc == ec, {"R8 arrival cycle ", tag}, cyc, ec);
        end
      end
      if (done) begin
        check(cyc == exp_done, {"R9 done cycle ", tag}, cyc, exp_done);
        exp_done = -1;
      end
    end
  end

  task automatic load_frame();
    for (int i = 0; i < 18; i++) begin
      @(negedge clk); smp_we = 1; smp_addr = 5'(i); smp_data = 16'(bs[i]);
    end
    for (int i = 0; i < 21; i++) begin
      @(negedge clk); smp_we = 0; coef_we = 1; coef_addr = 5'(i); coef_data = 16'(bc[i]);
    end
    @(negedge clk); smp_we = 0; coef_we = 0;
  endtask

  task automatic run_frame(input string t, input bit disturb);
    @(negedge clk);
    tag = t;
    for (int j = 0; j < 6; j++) begin
      exp_val.push_back(model(j/2, j%2));
      exp_cyc.push_back(cyc + 1 + 3*j + 3);
    end
    exp_done = cyc + 1 + 19;
    start = 1;
    @(negedge clk); start = 0;
    if (disturb) begin
      repeat (4) @(negedge clk);
      start = 1; smp_we = 1; smp_addr = 5'd3; smp_data = 16'h7fff;
      coef_we = 1; coef_addr = 5'd2; coef_data = 16'h7fff;
      @(negedge clk);
      start = 0; smp_we = 0; coef_we = 0;
    end
    repeat (26) @(negedge clk);
    check(exp_val.size() == 0, {"R7 all outputs seen ", t}, exp_val.size(), 0);
    check(exp_done == -1, {"R9 done seen ", t}, exp_done, -1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog", cyc, 0);
    finish_test();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!feat_valid && !done && !busy, "R1 reset state", {feat_valid, done, busy}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 18; i++) bs[i] = ((i*37) % 101 - 50) * 16;
    for (int i = 0; i < 21; i++) bc[i] = ((i*13) % 17 - 8) * 32;
    load_frame();
    run_frame("R2 R3 mixed", 0);

    for (int i = 0; i < 18; i++) bs[i] = (i % 9 < 5) ? (i % 9) * 256 : (9 - i % 9) * 300 - i * 20;
    for (int i = 0; i < 21; i++) bc[i] = (i / 7 == 1) ? -(i % 7) * 40 : (i % 7 + 1) * 50 - (i / 7) * 100;
    load_frame();
    run_frame("R6 shaped rows", 0);

    for (int i = 0; i < 18; i++) bs[i] = 100 + i * 50;
    for (int i = 0; i < 21; i++) bc[i] = -64 - i;
    load_frame();
    run_frame("R5 all negative", 0);

    for (int i = 0; i < 18; i++) bs[i] = 32767;
    for (int i = 0; i < 21; i++) bc[i] = (i < 14) ? 32767 : -32768;
    load_frame();
    run_frame("R4 clip", 0);

    for (int i = 0; i < 18; i++) bs[i] = (i * 53) % 97 * 10 - 300;
    for (int i = 0; i < 21; i++) bc[i] = (i * 29) % 23 * 20 - 150;
    load_frame();
    run_frame("R10 disturbed pass", 1);
    run_frame("R10 stored data intact", 0);

    finish_test();
  end
endmodule